// File: doc/BRIEF.md
# Dual-Width Condition-Code Integer ALU

This unit performs one integer operation per clock on two 64-bit operands. The operations are plain add, add with carry-in, subtract, subtract with borrow-in, six bitwise operations, and four tagged add/subtract forms. It registers the 64-bit result and an 8-bit flags byte. Every operation produces two flag sets at once. One set describes the low 32 bits of the result and the other describes the full 64 bits.

The carry-in for the chained forms comes from bit 0 of the unit's own flags register. The tagged forms treat any operand whose two lowest bits are not zero as a tag fault. Two of these forms also raise a trap request. While the trap request is high, nothing is committed.

Top module: `dualcc_alu`

## Requirements
- R1: After reset the registered result is zero, the flags byte is 0x00, and `tag_trap` is low.
- R2: The flags byte holds carry32 at bit 0, overflow32 at bit 1, zero32 at bit 2, negative32 at bit 3, carry64 at bit 4, overflow64 at bit 5, zero64 at bit 6 and negative64 at bit 7. Zero32 is set when result bits 31:0 are all zero and zero64 when all 64 bits are zero. Negative32 copies result bit 31 and negative64 copies bit 63.
- R3: Opcode 0x10 adds the operands. Carry32 and carry64 are the unsigned carries out of bit 31 and bit 63. Each overflow flag is set when the signed sum is out of range at its width.
- R4: Opcode 0x14 computes op_a minus op_b. Each carry flag reports an unsigned borrow at its width. Each overflow flag reports a signed out-of-range difference at its width.
- R5: Opcode 0x18 adds the stored flags bit 0 into the sum. Opcode 0x1C subtracts it from the difference. Flags follow the same rules as R3 and R4.
- R6: Opcodes 0x11 and, 0x12 or, 0x13 xor, 0x15 and-not (a & ~b), 0x16 or-not (a | ~b) and 0x17 xnor produce the bitwise result. Their zero and negative flags follow R2, and all four carry and overflow flags are cleared.
- R7: Opcodes 0x20 (tagged add) and 0x21 (tagged subtract) compute like R3 and R4. Their overflow32 is additionally set when bits 1:0 of either operand are nonzero. They never raise `tag_trap`.
- R8: Opcodes 0x22 (tagged add) and 0x23 (tagged subtract) are the trapping forms. While `wr_en` is high and the R7 overflow32 condition holds, `tag_trap` is high in the same cycle and neither result nor flags change. Otherwise they commit like 0x20 and 0x21.
- R9: Result and flags are written only on a clock edge where `wr_en` is high and the opcode is one of those listed above. With `wr_en` low or any other opcode, both hold their values and `tag_trap` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| opcode | input | 6 | Operation select |
| wr_en | input | 1 | Commit strobe for result and flags |
| result | output | 64 | Registered result |
| flags | output | 8 | Registered condition-code byte |
| tag_trap | output | 1 | Tag-overflow trap request, combinational |

## Verification
The assertions assume that opcode and wr_en are known and stable across each rising edge. They also assume that reset is the only event that changes the registers other than a commit. The stimulus therefore changes all inputs on the falling edge and holds them for a full cycle. It drops `wr_en` between scenarios so that no unintended commit happens. The chained opcodes depend on flags bit 0, so the carry or borrow is first established with a known operation in the preceding cycle.

// File: rtl/dualcc_pkg.sv
package dualcc_pkg;
  localparam int DW   = 64;
  localparam int LW   = 32;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_ADD   = 6'h10;
  localparam logic [OP_W-1:0] OPC_AND   = 6'h11;
  localparam logic [OP_W-1:0] OPC_OR    = 6'h12;
  localparam logic [OP_W-1:0] OPC_XOR   = 6'h13;
  localparam logic [OP_W-1:0] OPC_SUB   = 6'h14;
  localparam logic [OP_W-1:0] OPC_ANDN  = 6'h15;
  localparam logic [OP_W-1:0] OPC_ORN   = 6'h16;
  localparam logic [OP_W-1:0] OPC_XNOR  = 6'h17;
  localparam logic [OP_W-1:0] OPC_ADDC  = 6'h18;
  localparam logic [OP_W-1:0] OPC_SUBB  = 6'h1C;
  localparam logic [OP_W-1:0] OPC_TADD  = 6'h20;
  localparam logic [OP_W-1:0] OPC_TSUB  = 6'h21;
  localparam logic [OP_W-1:0] OPC_TADDT = 6'h22;
  localparam logic [OP_W-1:0] OPC_TSUBT = 6'h23;

  typedef enum logic [2:0] {
    LG_AND, LG_OR, LG_XOR, LG_ANDN, LG_ORN, LG_XNOR
  } logic_sel_e;

  // signed overflow for x + y = r, given the sign bits
  function automatic logic sgn_ovf(input logic sx, input logic sy, input logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

  // packs the two flag sets into the condition-code byte
  function automatic logic [7:0] pack_cc(input logic [DW-1:0] r,
                                         input logic c_lo, input logic v_lo,
                                         input logic c_hi, input logic v_hi);
    return {r[DW-1], (r == '0), v_hi, c_hi,
            r[LW-1], (r[LW-1:0] == '0), v_lo, c_lo};
  endfunction
endpackage

// File: rtl/dualcc_arith.sv
module dualcc_arith
  import dualcc_pkg::*;
#(
  parameter int W  = DW,
  parameter int LO = LW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_lo,
  output logic         v_lo,
  output logic         c_hi,
  output logic         v_hi
);
  logic [W-1:0]  b_eff;
  logic [LO:0]   lo_sum;
  logic [W:0]    full_sum;

  always_comb begin
    b_eff    = do_sub ? ~b : b;
    lo_sum   = {1'b0, a[LO-1:0]} + {1'b0, b_eff[LO-1:0]} + {{LO{1'b0}}, cin};
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum      = full_sum[W-1:0];
    // subtract reports borrow: inverse of the adder carry
    c_lo     = lo_sum[LO] ^ do_sub;
    c_hi     = full_sum[W] ^ do_sub;
    v_lo     = sgn_ovf(a[LO-1], b_eff[LO-1], full_sum[LO-1]);
    v_hi     = sgn_ovf(a[W-1], b_eff[W-1], full_sum[W-1]);
  end
endmodule

// File: rtl/dualcc_logic.sv
module dualcc_logic
  import dualcc_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      LG_ANDN: y = a & ~b;
      LG_ORN:  y = a | ~b;
      LG_XNOR: y = ~(a ^ b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dualcc_alu.sv
module dualcc_alu
  import dualcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  input  logic [OP_W-1:0] opcode,
  input  logic            wr_en,
  output logic [DW-1:0]   result,
  output logic [7:0]      flags,
  output logic            tag_trap
);
  // decode
  logic       dec_valid, dec_sub, dec_logic, dec_tag, dec_trapop;
  logic       dec_cin;
  logic_sel_e dec_lsel;

  always_comb begin
    dec_valid = 1'b1; dec_sub = 1'b0; dec_logic = 1'b0;
    dec_tag = 1'b0; dec_trapop = 1'b0; dec_cin = 1'b0; dec_lsel = LG_AND;
    case (opcode)
      OPC_ADD:   ;
      OPC_ADDC:  dec_cin = flags[0];
      OPC_SUB:   begin dec_sub = 1'b1; dec_cin = 1'b1; end
      OPC_SUBB:  begin dec_sub = 1'b1; dec_cin = ~flags[0]; end
      OPC_TADD:  dec_tag = 1'b1;
      OPC_TSUB:  begin dec_tag = 1'b1; dec_sub = 1'b1; dec_cin = 1'b1; end
      OPC_TADDT: begin dec_tag = 1'b1; dec_trapop = 1'b1; end
      OPC_TSUBT: begin dec_tag = 1'b1; dec_trapop = 1'b1; dec_sub = 1'b1; dec_cin = 1'b1; end
      OPC_AND:   begin dec_logic = 1'b1; dec_lsel = LG_AND;  end
      OPC_OR:    begin dec_logic = 1'b1; dec_lsel = LG_OR;   end
      OPC_XOR:   begin dec_logic = 1'b1; dec_lsel = LG_XOR;  end
      OPC_ANDN:  begin dec_logic = 1'b1; dec_lsel = LG_ANDN; end
      OPC_ORN:   begin dec_logic = 1'b1; dec_lsel = LG_ORN;  end
      OPC_XNOR:  begin dec_logic = 1'b1; dec_lsel = LG_XNOR; end
      default:   dec_valid = 1'b0;
    endcase
  end

  // datapaths
  logic [DW-1:0] ar_sum, lg_res;
  logic          ar_c_lo, ar_v_lo, ar_c_hi, ar_v_hi;

  dualcc_arith #(.W(DW), .LO(LW)) u_arith (
    .a(op_a), .b(op_b), .do_sub(dec_sub), .cin(dec_cin),
    .sum(ar_sum), .c_lo(ar_c_lo), .v_lo(ar_v_lo), .c_hi(ar_c_hi), .v_hi(ar_v_hi)
  );

  dualcc_logic #(.W(DW)) u_logic (
    .a(op_a), .b(op_b), .sel(dec_lsel), .y(lg_res)
  );

  // named events
  logic          tag_misalign, tag_v_lo, commit;
  logic [DW-1:0] next_res;
  logic [7:0]    next_cc;

  assign tag_misalign = (op_a[1:0] != 2'b00) || (op_b[1:0] != 2'b00);
  assign tag_v_lo     = ar_v_lo | (dec_tag & tag_misalign);
  assign tag_trap     = wr_en & dec_valid & dec_trapop & tag_v_lo;
  assign commit       = wr_en & dec_valid & ~tag_trap;

  always_comb begin
    if (dec_logic) begin
      next_res = lg_res;
      next_cc  = pack_cc(lg_res, 1'b0, 1'b0, 1'b0, 1'b0);
    end else begin
      next_res = ar_sum;
      next_cc  = pack_cc(ar_sum, ar_c_lo, tag_v_lo, ar_c_hi, ar_v_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flags  <= 8'h00;
    end else if (commit) begin
      result <= next_res;
      flags  <= next_cc;
    end
  end

  // assertions
  a_r8_trap_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    tag_trap |=> ($stable(result) && $stable(flags)));

  a_r8_trap_only_trapping_ops: assert property (@(posedge clk) disable iff (!rst_n)
    tag_trap |-> (wr_en && (opcode == OPC_TADDT || opcode == OPC_TSUBT)));

  a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(result) && $stable(flags)));

  a_r6_logic_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && dec_logic) |=> (flags[0] == 1'b0 && flags[1] == 1'b0 &&
                               flags[4] == 1'b0 && flags[5] == 1'b0));

  a_r2_zero_wide_implies_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    flags[6] |-> (flags[2] && result == '0));

  a_r2_sign_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[7] == result[DW-1]) && (flags[3] == result[LW-1]));
endmodule

// File: tb/test_dualcc_alu.sv
`timescale 1ns/1ps
module test_dualcc_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [5:0]  opcode = 6'h00;
  logic        wr_en = 1'b0;
  logic [63:0] result;
  logic [7:0]  flags;
  logic        tag_trap;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [63:0] m_res = '0;
  logic [7:0]  m_flg = '0;

  always #2 clk = ~clk;

  dualcc_alu i_dualcc_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .wr_en(wr_en), .result(result), .flags(flags), .tag_trap(tag_trap)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // reference computed from the requirements with exact wide arithmetic
  function automatic void model(input logic [5:0] op, input logic [63:0] a, input logic [63:0] b,
                                input logic c0, output logic [63:0] r, output logic [7:0] f,
                                output logic trap, output logic vld);
    logic sub, ci, tag, trp, lg;
    logic [63:0] lr;
    logic [65:0] ex, ua;
    logic [33:0] ex32, ua32;
    logic c32, v32, c64, v64;
    vld = 1'b1; sub = 1'b0; ci = 1'b0; tag = 1'b0; trp = 1'b0; lg = 1'b0; lr = '0;
    case (op)
      6'h10: ;
      6'h18: ci = c0;
      6'h14: sub = 1'b1;
      6'h1C: begin sub = 1'b1; ci = c0; end
      6'h20: tag = 1'b1;
      6'h21: begin tag = 1'b1; sub = 1'b1; end
      6'h22: begin tag = 1'b1; trp = 1'b1; end
      6'h23: begin tag = 1'b1; trp = 1'b1; sub = 1'b1; end
      6'h11: begin lg = 1'b1; lr = a & b; end
      6'h12: begin lg = 1'b1; lr = a | b; end
      6'h13: begin lg = 1'b1; lr = a ^ b; end
      6'h15: begin lg = 1'b1; lr = a & ~b; end
      6'h16: begin lg = 1'b1; lr = a | ~b; end
      6'h17: begin lg = 1'b1; lr = ~(a ^ b); end
      default: vld = 1'b0;
    endcase
    if (sub) begin
      ex   = {{2{a[63]}}, a} - {{2{b[63]}}, b} - {65'b0, ci};
      ex32 = {{2{a[31]}}, a[31:0]} - {{2{b[31]}}, b[31:0]} - {33'b0, ci};
      c64  = ({2'b0, a} < ({2'b0, b} + {65'b0, ci}));
      c32  = ({2'b0, a[31:0]} < ({2'b0, b[31:0]} + {33'b0, ci}));
    end else begin
      ex   = {{2{a[63]}}, a} + {{2{b[63]}}, b} + {65'b0, ci};
      ex32 = {{2{a[31]}}, a[31:0]} + {{2{b[31]}}, b[31:0]} + {33'b0, ci};
      ua   = {2'b0, a} + {2'b0, b} + {65'b0, ci};
      ua32 = {2'b0, a[31:0]} + {2'b0, b[31:0]} + {33'b0, ci};
      c64  = ua[64];
      c32  = ua32[32];
    end
    v64 = !(ex[65] == ex[63] && ex[64] == ex[63]);
    v32 = !(ex32[33] == ex32[31] && ex32[32] == ex32[31]);
    r = ex[63:0];
    if (tag) v32 = v32 | (a[1:0] != 2'b00) | (b[1:0] != 2'b00);
    trap = trp & v32;
    if (lg) begin r = lr; c32 = 0; v32 = 0; c64 = 0; v64 = 0; end
    f = {r[63], (r == 64'd0), v64, c64, r[31], (r[31:0] == 32'd0), v32, c32};
  endfunction

  task automatic run(input string req, input logic [5:0] op, input logic [63:0] a,
                     input logic [63:0] b, input logic we);
    logic [63:0] r; logic [7:0] f; logic tr, vld;
    model(op, a, b, m_flg[0], r, f, tr, vld);
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; wr_en = we;
    #1 chk({req, " trap"}, {63'b0, tag_trap}, {63'b0, we & vld & tr});
    if (we && vld && !tr) begin m_res = r; m_flg = f; end
    @(posedge clk); #1;
    chk({req, " result"}, result, m_res);
    chk({req, " flags"}, {56'b0, flags}, {56'b0, m_flg});
  endtask

  task automatic idle();
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 result", result, 64'd0);
    chk("R1 flags", {56'b0, flags}, 64'd0);
    chk("R1 trap", {63'b0, tag_trap}, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_add();
    run("R3 plain", 6'h10, 64'd100, 64'd23, 1);
    run("R3 c32 z32", 6'h10, 64'h0000_0000_FFFF_FFFF, 64'd1, 1);
    run("R3 v64 n64", 6'h10, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1);
    run("R2 c64 z64", 6'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1);
    run("R3 v32 n32", 6'h10, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001, 1);
    idle();
  endtask

  task automatic t_sub();
    run("R4 borrow", 6'h14, 64'd5, 64'd7, 1);
    run("R4 v64", 6'h14, 64'h8000_0000_0000_0000, 64'd1, 1);
    run("R4 zero", 6'h14, 64'd3, 64'd3, 1);
    run("R4 v32", 6'h14, 64'h0000_0000_8000_0000, 64'd1, 1);
    idle();
  endtask

  task automatic t_chain();
    run("R5 set carry", 6'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 1);
    run("R5 adc with carry", 6'h18, 64'd1, 64'd1, 1);
    run("R5 adc no carry", 6'h18, 64'd1, 64'd1, 1);
    run("R5 set borrow", 6'h14, 64'd0, 64'd1, 1);
    run("R5 sbb with borrow", 6'h1C, 64'd10, 64'd3, 1);
    run("R5 sbb no borrow", 6'h1C, 64'd10, 64'd3, 1);
    idle();
  endtask

  task automatic t_logic();
    run("R6 pre carry", 6'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 1);
    run("R6 and", 6'h11, 64'hF0F0_0000_FFFF_0000, 64'hFF00_0000_00FF_0000, 1);
    run("R6 or", 6'h12, 64'h0, 64'h0, 1);
    run("R6 xor", 6'h13, 64'h8000_0000_8000_0000, 64'h0000_0000_8000_0000, 1);
    run("R6 andn", 6'h15, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1);
    run("R6 orn", 6'h16, 64'h0, 64'h0000_0000_FFFF_FFFF, 1);
    run("R6 xnor", 6'h17, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1);
    idle();
  endtask

  task automatic t_tagged();
    run("R7 tadd aligned", 6'h20, 64'd8, 64'd4, 1);
    run("R7 tadd misaligned", 6'h20, 64'd9, 64'd4, 1);
    run("R7 tadd ovf", 6'h20, 64'h0000_0000_7FFF_FFFC, 64'd4, 1);
    run("R7 tsub misaligned b", 6'h21, 64'd16, 64'd2, 1);
    run("R7 tsub aligned", 6'h21, 64'd16, 64'd4, 1);
    idle();
  endtask

  task automatic t_trap();
    run("R8 taddt misaligned", 6'h22, 64'd5, 64'd8, 1);
    run("R8 taddt ovf", 6'h22, 64'h0000_0000_7FFF_FFFC, 64'd4, 1);
    run("R8 taddt ok", 6'h22, 64'd12, 64'd8, 1);
    run("R8 tsubt misaligned", 6'h23, 64'd12, 64'd3, 1);
    run("R8 tsubt ok", 6'h23, 64'd12, 64'd20, 1);
    idle();
  endtask

  task automatic t_hold();
    run("R9 no strobe", 6'h10, 64'd1, 64'd1, 0);
    run("R9 no strobe trap op", 6'h22, 64'd1, 64'd1, 0);
    run("R9 unlisted opcode", 6'h19, 64'd77, 64'd1, 1);
    run("R9 unlisted opcode 2", 6'h00, 64'd0, 64'd0, 1);
    idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_chain();
    t_logic();
    t_tagged();
    t_trap();
    t_hold();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule